// File: doc/BRIEF.md
# Triggered Time-Binned Pulse Counter

This block builds a histogram of pulse counts against time after a trigger. A rising edge on the trigger level starts a sweep. The sweep divides time into a fixed number of equal bins, each a fixed number of processing-clock cycles long. A single-cycle strobe from an upstream discriminator marks each detected pulse. Within a bin the strobes are summed by a saturating counter. At every bin boundary that sum is stored in an on-chip memory, at the address equal to the bin number, and the counter restarts.

At the default settings the clock is 250 MHz, a bin lasts 10 µs (2500 cycles) and a sweep covers 3000 bins. A host reads the stored counts by bin number through a registered read port. Reads are served only after the sweep has finished and the trigger has gone low again. The running count of the current bin is driven on a separate output, so it can feed an analog monitor.

Top module: `thc_hist_counter`

## Requirements
- R1: While reset is held and after it is released, `state_o` is 2'b00 (idle), `rd_valid_o` is 0 and `mon_cnt_o` is 0.
- R2: A trigger rising edge passes a two-flop synchronizer. When the trigger is first high at clock edge k, `state_o` becomes 2'b01 (counting) after edge k+2, and a strobe sampled at edge k+2 is the first one counted into bin 0.
- R3: Call the strobe sampled at edge k+2 offset t=0. A strobe at offset t is counted into bin t / CYC_PER_BIN. A strobe on a bin's boundary cycle (t a multiple of CYC_PER_BIN) therefore starts the new bin's count.
- R4: The sweep covers exactly NUM_BINS bins. After edge k+2+NUM_BINS*CYC_PER_BIN the state leaves counting. It becomes 2'b11 (done) if the synchronized trigger is low at that edge, and otherwise 2'b10 (holding). A strobe on that final edge is discarded.
- R5: The per-bin count saturates at 2^CNT_W-1 and never wraps.
- R6: A trigger rising edge during counting is ignored: bin timing, counts and the end of the sweep are unchanged.
- R7: A read (`rd_en_i` high) is accepted only in the done state. An accepted read raises `rd_valid_o` after the next edge with the stored count on `rd_data_o`. Any other read gives `rd_valid_o` = 0, and `rd_data_o` holds its previous value.
- R8: An accepted read of an address at or above NUM_BINS returns 0 with `rd_valid_o` = 1.
- R9: While counting, `mon_cnt_o` shows the current bin's running count after each edge.
- R10: In the holding state the block moves to done three edges after the trigger input first goes low: it stays holding after the first and second of those edges and is done after the third.
- R11: A trigger rising edge in the done state starts a new sweep, and the new sweep overwrites every bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger level, asynchronous |
| pulse_i | input | 1 | Single-cycle pulse-detect strobe |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW = clog2(NUM_BINS) | Bin number to read |
| rd_data_o | output | CNT_W | Stored count of the bin that was read |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted request |
| state_o | output | 2 | 00 idle, 01 counting, 10 holding, 11 done |
| mon_cnt_o | output | CNT_W | Running count of the current bin |

## Verification
The assertions check on every cycle the rules that are local in time. A rising edge starts a sweep only from idle or done. Bins advance only on boundaries, and the state leaves counting right after the last boundary. Memory writes happen only while counting. The running count steps by at most one and stays at its maximum once there, and reads are gated to the done state.

Only the bench scenarios can show the stored histogram. They check the exact per-bin contents against a model under random, saturating and boundary-only strobe patterns. They also cover a trigger that drops and rises again mid-sweep, both exits (directly to done, or through holding), out-of-range reads, and a second sweep that overwrites the first.

// File: rtl/thc_pkg.sv
package thc_pkg;

  // Sweep sequencing states; the encoding is visible on state_o.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_COUNT = 2'b01,
    ST_HOLD  = 2'b10,
    ST_DONE  = 2'b11
  } thc_state_e;

endpackage

// File: rtl/thc_trig_sync.sv
module thc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], din_i};
    end else begin : g_single
      assign sync_d = din_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/thc_bin_timer.sv
module thc_bin_timer #(
  parameter int CYC_PER_BIN = 2500,
  parameter int NUM_BINS    = 3000,
  localparam int CW = (CYC_PER_BIN > 1) ? $clog2(CYC_PER_BIN) : 1,
  localparam int AW = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  output logic          bin_end_o,
  output logic          last_o,
  output logic [AW-1:0] bin_o
);

  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_BIN - 1);
  localparam logic [AW-1:0] BIN_LAST = AW'(NUM_BINS - 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [AW-1:0] bin_q, bin_d;
  logic          bin_end;
  logic          last;

  assign bin_end = run_i && (cyc_q == CYC_LAST);
  assign last    = bin_end && (bin_q == BIN_LAST);

  always_comb begin
    cyc_d = cyc_q;
    bin_d = bin_q;
    if (start_i) begin
      cyc_d = '0;
      bin_d = '0;
    end else if (run_i) begin
      if (bin_end) begin
        cyc_d = '0;
        if (!last) begin
          bin_d = bin_q + 1'b1;
        end
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      bin_q <= '0;
    end else if (start_i || run_i) begin
      cyc_q <= cyc_d;
      bin_q <= bin_d;
    end
  end

  assign bin_end_o = bin_end;
  assign last_o    = last;
  assign bin_o     = bin_q;

endmodule

// File: rtl/thc_pulse_acc.sv
module thc_pulse_acc #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             bin_end_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i || (run_i && bin_end_i)) begin
      // a fresh bin begins with this cycle's strobe already in it
      cnt_d  = CNT_W'(pulse_i);
      cnt_en = 1'b1;
    end else if (run_i && pulse_i && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/thc_hist_mem.sv
module thc_hist_mem #(
  parameter int DEPTH = 3000,
  parameter int DW    = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvalid_q;
  logic          in_range;

  assign in_range = ({1'b0, raddr_i} < (AW+1)'(DEPTH));

  always_comb begin
    rdata_d = '0;
    if (in_range) begin
      rdata_d = mem_q[raddr_i];
    end
  end

  // Storage array carries no reset.
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/thc_hist_counter.sv
module thc_hist_counter
  import thc_pkg::*;
#(
  parameter int CYC_PER_BIN = 2500,
  parameter int NUM_BINS    = 3000,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             pulse_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] mon_cnt_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n = rst_pipe_q[1];

  // Trigger synchronizer and edge detection.
  logic trig_lvl;
  logic trig_rise;

  thc_trig_sync #(
    .STAGES (SYNC_STAGES)
  ) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .din_i  (trig_i),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise)
  );

  // Sequencing.
  thc_state_e state_q, state_d;
  logic       sweep_start;
  logic       sweep_run;
  logic       bin_end;
  logic       sweep_last;
  logic       rd_accept;

  assign sweep_run   = (state_q == ST_COUNT);
  assign sweep_start = trig_rise && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign rd_accept   = rd_en_i && (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (trig_rise) begin
          state_d = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (sweep_last) begin
          state_d = trig_lvl ? ST_HOLD : ST_DONE;
        end
      end
      ST_HOLD: begin
        if (!trig_lvl) begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Bin timing and index.
  logic [AW-1:0] bin_idx;

  thc_bin_timer #(
    .CYC_PER_BIN (CYC_PER_BIN),
    .NUM_BINS    (NUM_BINS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (sweep_start),
    .run_i     (sweep_run),
    .bin_end_o (bin_end),
    .last_o    (sweep_last),
    .bin_o     (bin_idx)
  );

  // Per-bin saturating counter.
  logic [CNT_W-1:0] acc_cnt;

  thc_pulse_acc #(
    .CNT_W (CNT_W)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (sweep_start),
    .run_i     (sweep_run),
    .bin_end_i (bin_end),
    .pulse_i   (pulse_i),
    .cnt_o     (acc_cnt)
  );

  // Histogram storage.
  thc_hist_mem #(
    .DEPTH (NUM_BINS),
    .DW    (CNT_W)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .we_i     (bin_end),
    .waddr_i  (bin_idx),
    .wdata_i  (acc_cnt),
    .re_i     (rd_accept),
    .raddr_i  (rd_addr_i),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );

  assign state_o   = state_q;
  assign mon_cnt_o = acc_cnt;

endmodule

// File: rtl/thc_hist_counter_chk.sv
module thc_hist_counter_chk
  import thc_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int AW    = 12
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic             rise,
  input logic             bin_end,
  input logic             last,
  input logic [AW-1:0]    bin,
  input logic [CNT_W-1:0] cnt,
  input logic             rd_en,
  input logic             rd_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_start_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (((state == ST_IDLE) || (state == ST_DONE)) && rise) |=> (state == ST_COUNT));

  p_bin_held_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == ST_COUNT) && !bin_end) |=> ((state == ST_COUNT) && $stable(bin)));

  p_sweep_end_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    last |=> ((state == ST_HOLD) || (state == ST_DONE)));

  p_write_window_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    bin_end |-> (state == ST_COUNT));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == ST_COUNT) && !bin_end && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX));

  p_mon_step_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == ST_COUNT) && !bin_end) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

  p_new_bin_start_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    bin_end |=> (cnt <= CNT_W'(1)));

  p_read_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en && (state != ST_DONE)) |=> !rd_valid);

  p_read_served_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en && (state == ST_DONE)) |=> rd_valid);

endmodule

bind thc_hist_counter thc_hist_counter_chk #(
  .CNT_W (CNT_W),
  .AW    (AW)
) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n),
  .state    (state_q),
  .rise     (trig_rise),
  .bin_end  (bin_end),
  .last     (sweep_last),
  .bin      (bin_idx),
  .cnt      (acc_cnt),
  .rd_en    (rd_en_i),
  .rd_valid (rd_valid_o)
);

// File: tb/tb_thc_hist_counter.sv
module tb_thc_hist_counter;

  localparam int CLK_PERIOD = 10;
  localparam int P_CYC  = 10;
  localparam int P_BINS = 12;
  localparam int P_W    = 3;
  localparam int AW     = $clog2(P_BINS);
  localparam int MAXC   = (1 << P_W) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig;
  logic          pulse;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [P_W-1:0] rd_data;
  logic          rd_valid;
  logic [1:0]    state;
  logic [P_W-1:0] mon;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_bins [P_BINS];

  always #(CLK_PERIOD/2) clk = ~clk;

  thc_hist_counter #(
    .CYC_PER_BIN (P_CYC),
    .NUM_BINS    (P_BINS),
    .CNT_W       (P_W)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .trig_i     (trig),
    .pulse_i    (pulse),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid),
    .state_o    (state),
    .mon_cnt_o  (mon)
  );

  function automatic int sat_add(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  function automatic int exp_read(input int a);
    return (a < P_BINS) ? exp_bins[a] : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, sample just after the rising edge.
  task automatic step(input logic tg, input logic pl, input logic re, input int ad);
    @(negedge clk);
    trig    = tg;
    pulse   = pl;
    rd_en   = re;
    rd_addr = AW'(ad);
    @(posedge clk);
    #1;
  endtask

  // mode 0: random strobes, mode 1: strobe every cycle, mode 2: boundary cycles only
  task automatic run_sweep(input int mode, input bit early_drop, input bit disturb);
    int run;
    logic [P_W-1:0] held;
    run = 0;
    for (int i = 0; i < P_BINS; i++) exp_bins[i] = 0;
    step(1'b1, 1'b0, 1'b0, 0);
    check(state != 2'b01, "R2 not counting one edge after trigger", state, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    check(state != 2'b01, "R2 not counting two edges after trigger", state, 0);
    held = rd_data;
    for (int t = 0; t < P_BINS*P_CYC; t++) begin
      logic p;
      logic tg;
      case (mode)
        0:       p = ($urandom_range(99) < 30);
        1:       p = 1'b1;
        default: p = ((t % P_CYC) == 0);
      endcase
      tg = 1'b1;
      if (early_drop && (t >= P_BINS*P_CYC - 6)) tg = 1'b0;
      if (disturb && (t >= 20) && (t < 25)) tg = 1'b0;
      if ((t % P_CYC) == 0) run = p ? 1 : 0;
      else if (p) run = sat_add(run);
      exp_bins[t / P_CYC] = run;
      step(tg, p, (t == 7), 3);
      check(state == 2'b01, "R2/R6 counting through sweep", state, 1);
      check(mon == P_W'(run), "R9/R5/R3 running count", mon, run);
      if (t == 7) begin
        check(rd_valid == 1'b0, "R7 read refused while counting", rd_valid, 0);
        check(rd_data == held, "R7 read data held", rd_data, held);
      end
    end
    // final boundary edge; its strobe must not land anywhere
    step(early_drop ? 1'b0 : 1'b1, 1'b1, 1'b0, 0);
    if (early_drop) begin
      check(state == 2'b11, "R4 sweep end straight to done", state, 3);
    end else begin
      check(state == 2'b10, "R4 sweep end to holding", state, 2);
      step(1'b0, 1'b0, 1'b0, 0);
      check(state == 2'b10, "R10 holding after first low edge", state, 2);
      step(1'b0, 1'b0, 1'b0, 0);
      check(state == 2'b10, "R10 holding after second low edge", state, 2);
      step(1'b0, 1'b0, 1'b0, 0);
      check(state == 2'b11, "R10 done after third low edge", state, 3);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      step(1'b0, 1'b0, 1'b1, a);
      check(rd_valid == 1'b1, "R7 read valid in done", rd_valid, 1);
      if (a < P_BINS)
        check(rd_data == P_W'(exp_read(a)), "R11/R3/R5 bin content", rd_data, exp_read(a));
      else
        check(rd_data == '0, "R8 out-of-range bin reads zero", rd_data, 0);
    end
    held = rd_data;
    step(1'b0, 1'b0, 1'b0, 0);
    check(rd_valid == 1'b0, "R7 no valid without request", rd_valid, 0);
    check(rd_data == held, "R7 data held without request", rd_data, held);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; trig = 1'b0; pulse = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check(state == 2'b00, "R1 idle in reset", state, 0);
    check(rd_valid == 1'b0, "R1 no valid in reset", rd_valid, 0);
    check(mon == '0, "R1 monitor zero in reset", mon, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b1, 1'b0, 0);
    check(state == 2'b00, "R1 idle after reset", state, 0);
    check(mon == '0, "R1 strobes ignored in idle", mon, 0);
    step(1'b0, 1'b0, 1'b1, 2);
    check(rd_valid == 1'b0, "R7 read refused in idle", rd_valid, 0);

    run_sweep(0, 1'b1, 1'b0);   // random strobes, trigger low before end
    run_sweep(1, 1'b0, 1'b1);   // saturating bins, mid-sweep re-trigger, holding exit
    run_sweep(2, 1'b1, 1'b0);   // boundary-only strobes, second overwrite
    run_sweep(0, 1'b0, 1'b0);   // random strobes again, holding exit
    finish_run();
  end

endmodule